// File: doc/BRIEF.md
# Serial DAC Interface Controller

This block is the digital front end of a 14-bit voltage-output converter. A host writes 16-bit words over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word carries a two-bit command in its top bits and a 14-bit code below it. The command decides how the code moves through two stacked registers. The first is a staging register that holds the next code. The second is the output register that drives the converter. The host can stage a code without disturbing the output, copy the staged code to the output, or write both registers at once.

The block also keeps a low-power sleep state. A serial command or a sleep pin puts it to sleep, but only while a permission pin is high. While the permission pin is low, sleep cannot be entered. A falling edge on that pin wakes the block. A command that writes both registers also wakes it. Releasing the sleep pin does not wake it. While the block sleeps, the serial link keeps working and both registers keep their contents. The block reports the sleep state through a flag and through an output-enable that goes low to show the analog output is high impedance.

The serial pins and the two control pins are asynchronous to the system clock. They pass through a synchronizer and are processed on the system clock.

Top module: `sdac_front`

## Requirements
- R1: Reset (synchronous, active-high `rst`) clears the staging and output registers to zero, clears `shutdown` and sets `out_en` to 1.
- R2: A frame starts on a falling edge of `ser_cs_n`. While `ser_cs_n` is low, one bit of `ser_data` is taken on each rising edge of `ser_clk`, MSB first. Bits [15:14] of the word are the command and bits [13:0] are the code. The command acts on the rising edge of `ser_cs_n`.
- R3: Command 2'b00 loads the code into the staging register and leaves `dac_code` unchanged.
- R4: Command 2'b01 copies the staging register to the output register (`dac_code`). Its code bits are ignored.
- R5: Command 2'b10 loads the code into both registers, and it takes the block out of sleep unless the sleep pin is holding it there.
- R6: While `pd_allow` is high, command 2'b11 puts the block to sleep. Its code bits are ignored and `dac_code` keeps its value.
- R7: A frame with a clock count other than 16 (for example 15 or 17) is discarded and changes no register.
- R8: While `pd_allow` is high, driving `sd_pin` high puts the block to sleep. Driving `sd_pin` low again does not wake it.
- R9: While `pd_allow` is low, `shutdown` stays 0, whatever `sd_pin` does and whatever commands arrive.
- R10: A high-to-low transition of `pd_allow` wakes the block. After waking, `dac_code` has the value it held before sleep.
- R11: While asleep, `out_en` is 0. Frames with commands 00 and 01 are still carried out, and neither one wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| sd_pin | input | 1 | Sleep request pin, active high |
| pd_allow | input | 1 | Sleep permission; low blocks sleep, falling edge wakes |
| dac_code | output | 14 | Output register contents |
| shutdown | output | 1 | Block is asleep |
| out_en | output | 1 | Analog output driven; 0 means high impedance |

## Verification
The hardest case to reach is a sleep period in which the two registers are rewritten, because the staging register is not visible at the ports. The bench stages a new code with command 00 while the block sleeps. It then copies that code out with command 01 and checks that `dac_code` follows while `shutdown` stays high. After that it wakes the block. The bench also forces the two wake paths apart: one wake comes from a falling edge on `pd_allow`, and the other comes from command 10. Frames one clock short and one clock long are sent between valid frames, and the bench confirms that they leave `dac_code` unchanged.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int CODE_W   = 14;
    localparam int CMD_W    = 2;
    localparam int WORD_W   = CMD_W + CODE_W;
    localparam int CNT_W    = $clog2(WORD_W + 2);
    localparam int SYNC_N   = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_STAGE = 2'b00,
        CMD_COPY  = 2'b01,
        CMD_BOTH  = 2'b10,
        CMD_SLEEP = 2'b11
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [CODE_W-1:0] code;
    } frame_t;

    function automatic frame_t unpack_word(input logic [WORD_W-1:0] w);
        frame_t f;
        f.cmd  = cmd_e'(w[WORD_W-1 -: CMD_W]);
        f.code = w[CODE_W-1:0];
        return f;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n,
    input  logic   sck,
    input  logic   sdi,
    output logic   frame_stb,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

    logic                cs_prev, sck_prev;
    logic [WORD_W-1:0]   sreg;
    logic [CNT_W-1:0]    cnt, cnt_base, cnt_nxt;
    logic                cs_fall, cs_rise, bit_take;

    assign cs_fall  = cs_prev & ~cs_n;
    assign cs_rise  = ~cs_prev & cs_n;
    assign bit_take = ~sck_prev & sck & ~cs_n;

    always_comb begin
        cnt_base = cs_fall ? '0 : cnt;
        cnt_nxt  = cnt_base;
        if (bit_take && cnt_base != SAT)
            cnt_nxt = cnt_base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            sck_prev  <= 1'b0;
            sreg      <= '0;
            cnt       <= '0;
            frame_stb <= 1'b0;
            frame     <= '0;
        end else begin
            cs_prev   <= cs_n;
            sck_prev  <= sck;
            cnt       <= cnt_nxt;
            if (bit_take)
                sreg <= {sreg[WORD_W-2:0], sdi};
            frame_stb <= cs_rise && (cnt == FULL);
            if (cs_rise)
                frame <= unpack_word(sreg);
        end
    end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  frame_t            frame,
    input  logic              sd_req,
    input  logic              allow,
    output logic [CODE_W-1:0] stage_code,
    output logic [CODE_W-1:0] out_code,
    output logic              asleep
);
    logic sleep_nxt;

    always_comb begin
        sleep_nxt = asleep;
        if (!allow)
            sleep_nxt = 1'b0;
        else if (sd_req || (frame_stb && frame.cmd == CMD_SLEEP))
            sleep_nxt = 1'b1;
        else if (frame_stb && frame.cmd == CMD_BOTH)
            sleep_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_code <= '0;
            out_code   <= '0;
            asleep     <= 1'b0;
        end else begin
            asleep <= sleep_nxt;
            if (frame_stb) begin
                unique case (frame.cmd)
                    CMD_STAGE: stage_code <= frame.code;
                    CMD_COPY:  out_code   <= stage_code;
                    CMD_BOTH: begin
                        stage_code <= frame.code;
                        out_code   <= frame.code;
                    end
                    CMD_SLEEP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_cs_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              sd_pin,
    input  logic              pd_allow,
    output logic [CODE_W-1:0] dac_code,
    output logic              shutdown,
    output logic              out_en
);
    localparam int PIN_N = 5;
    localparam logic [PIN_N-1:0] PIN_RST = 5'b10000;

    logic [PIN_N-1:0]  pins_s;
    logic              cs_s, sck_s, sdi_s, sd_s, allow_s;
    logic              frame_stb;
    frame_t            frm;
    logic [CODE_W-1:0] stage_code;

    sdac_sync #(.W(PIN_N), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_cs_n, ser_clk, ser_data, sd_pin, pd_allow}),
        .q   (pins_s)
    );

    assign {cs_s, sck_s, sdi_s, sd_s, allow_s} = pins_s;

    sdac_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_s),
        .sck       (sck_s),
        .sdi       (sdi_s),
        .frame_stb (frame_stb),
        .frame     (frm)
    );

    sdac_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .frame_stb  (frame_stb),
        .frame      (frm),
        .sd_req     (sd_s),
        .allow      (allow_s),
        .stage_code (stage_code),
        .out_code   (dac_code),
        .asleep     (shutdown)
    );

    assign out_en = ~shutdown;
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input cmd_e              cmd,
    input logic [CODE_W-1:0] stage_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              shutdown,
    input logic              sd_s,
    input logic              allow_s
);
    // R1: first cycle out of reset shows cleared state
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_code == '0 && stage_code == '0 && !shutdown));

    // R2: a frame strobe lasts one cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> !frame_stb);

    // R3: output register moves only after a copy or dual-load frame
    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code) |-> ($past(frame_stb) &&
            ($past(cmd) == CMD_COPY || $past(cmd) == CMD_BOTH)));

    // R4: staging register moves only after a stage or dual-load frame
    p_stage_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(stage_code) |-> ($past(frame_stb) &&
            ($past(cmd) == CMD_STAGE || $past(cmd) == CMD_BOTH)));

    // R5: dual-load frame wakes the block when nothing keeps it asleep
    p_wake_both_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_stb) && $past(cmd) == CMD_BOTH && !$past(sd_s)) |-> !shutdown);

    // R6: sleep is entered only with permission
    p_enter_allowed_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(allow_s));

    // R9: permission low keeps the block awake
    p_lockout_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(allow_s) |-> !shutdown);
endmodule

bind sdac_front sdac_front_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .cmd        (frm.cmd),
    .stage_code (stage_code),
    .dac_code   (dac_code),
    .shutdown   (shutdown),
    .sd_s       (sd_s),
    .allow_s    (allow_s)
);

// File: tb/sdac_front_bench.sv
`timescale 1ns/1ps
module sdac_front_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_cs_n, ser_clk, ser_data, sd_pin, pd_allow;
    logic [13:0] dac_code;
    logic        shutdown, out_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    sdac_front u_sdac_front (
        .clk      (clk),
        .rst      (rst),
        .ser_cs_n (ser_cs_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .sd_pin   (sd_pin),
        .pd_allow (pd_allow),
        .dac_code (dac_code),
        .shutdown (shutdown),
        .out_en   (out_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [1:0] cmd, input logic [13:0] code, input int nbits);
        logic [16:0] w;
        w = {cmd, code, 1'b0};
        if (nbits == 17) w = {cmd, code, 1'b1};
        wait_clk(1);
        ser_cs_n = 1'b0;
        wait_clk(4);
        for (int i = 16; i > 16 - nbits; i--) begin
            ser_data = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send(input logic [1:0] cmd, input logic [13:0] code);
        send_bits(cmd, code, 16);
    endtask

    task automatic t_reset();
        check("R1 dac_code after reset", 16'(dac_code), 16'h0000);
        check("R1 shutdown after reset", 16'(shutdown), 16'h0);
        check("R1 out_en after reset",   16'(out_en),   16'h1);
    endtask

    task automatic t_stage_copy();
        send(2'b00, 14'h1234);
        check("R3 stage leaves dac_code", 16'(dac_code), 16'h0000);
        send(2'b01, 14'h3FFF);
        check("R4 copy moves staged code, R2 MSB-first", 16'(dac_code), 16'h1234);
        send(2'b01, 14'h0000);
        check("R4 repeated copy keeps code", 16'(dac_code), 16'h1234);
    endtask

    task automatic t_both();
        send(2'b10, 14'h2AAA);
        check("R5 dual load sets dac_code", 16'(dac_code), 16'h2AAA);
        send(2'b01, 14'h1555);
        check("R5 dual load also set staging", 16'(dac_code), 16'h2AAA);
    endtask

    task automatic t_bad_len();
        send_bits(2'b10, 14'h0555, 15);
        check("R7 15-clock frame discarded", 16'(dac_code), 16'h2AAA);
        send_bits(2'b10, 14'h0555, 17);
        check("R7 17-clock frame discarded", 16'(dac_code), 16'h2AAA);
        send(2'b01, 14'h0000);
        check("R7 staging untouched by bad frames", 16'(dac_code), 16'h2AAA);
    endtask

    task automatic t_cmd_sleep();
        send(2'b11, 14'h0001);
        check("R6 sleep command sets shutdown", 16'(shutdown), 16'h1);
        check("R11 out_en low while asleep",    16'(out_en),   16'h0);
        check("R6 dac_code kept in sleep",      16'(dac_code), 16'h2AAA);
    endtask

    task automatic t_asleep_frames();
        send(2'b00, 14'h0F0F);
        check("R11 stage frame keeps sleep", 16'(shutdown), 16'h1);
        check("R11 stage frame leaves dac_code", 16'(dac_code), 16'h2AAA);
        send(2'b01, 14'h0000);
        check("R11 copy while asleep", 16'(dac_code), 16'h0F0F);
        check("R11 copy keeps sleep",  16'(shutdown), 16'h1);
        send(2'b10, 14'h1111);
        check("R5 dual load wakes", 16'(shutdown), 16'h0);
        check("R5 dual load code",  16'(dac_code), 16'h1111);
    endtask

    task automatic t_pin_sleep();
        sd_pin = 1'b1;
        wait_clk(10);
        check("R8 sleep pin enters sleep", 16'(shutdown), 16'h1);
        sd_pin = 1'b0;
        wait_clk(10);
        check("R8 releasing pin keeps sleep", 16'(shutdown), 16'h1);
        check("R8 out_en low", 16'(out_en), 16'h0);
    endtask

    task automatic t_allow_wake();
        pd_allow = 1'b0;
        wait_clk(10);
        check("R10 permission fall wakes",   16'(shutdown), 16'h0);
        check("R10 code restored on wake",   16'(dac_code), 16'h1111);
        check("R10 out_en back high",        16'(out_en),   16'h1);
    endtask

    task automatic t_lockout();
        sd_pin = 1'b1;
        wait_clk(10);
        check("R9 pin blocked while locked", 16'(shutdown), 16'h0);
        send(2'b11, 14'h0000);
        check("R9 command blocked while locked", 16'(shutdown), 16'h0);
        sd_pin = 1'b0;
        wait_clk(4);
        pd_allow = 1'b1;
        wait_clk(10);
        check("R9 allow rise alone does not sleep", 16'(shutdown), 16'h0);
    endtask

    initial begin
        rst = 1'b1;
        ser_cs_n = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
        sd_pin = 1'b0;   pd_allow = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(1);
        t_reset();
        wait_clk(6);
        t_stage_copy();
        t_both();
        t_bad_len();
        t_cmd_sleep();
        t_asleep_frames();
        t_pin_sleep();
        t_allow_wake();
        t_lockout();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule